// File: doc/BRIEF.md
# NAND Write-Protect Lock Unit

This unit decides which erase and program operations may reach the NAND flash, and whether the host may write into the controller's page buffer RAM. Software configures a protection mode and an inclusive range of block numbers. Every program or erase request from the operation sequencer is checked against that configuration before it is passed on. A request that is refused is dropped, and a sticky flag records that it happened.

The protection mode is a three-state machine. LOCK_ALL refuses every request. UNLOCK_RANGE lets through requests whose block number lies inside the configured range. TIGHT refuses every request and freezes the mode and range registers until reset. Software moves between the states by writing a mode code. From LOCK_ALL or UNLOCK_RANGE, writing 4 moves to UNLOCK_RANGE, writing 2 moves to LOCK_ALL and writing 1 moves to TIGHT. TIGHT has no exit except reset.

Host writes into the buffer RAM are controlled separately, by a key register that does not depend on the flash mode.

Top module: `nand_wp_lock`

## Requirements
- R1: After reset the mode reads 2 (LOCK_ALL), the range start and end read 0, the buffer key reads 0, the buffer is locked, and the violation flag is clear.
- R2: A register write with select 0 and data 4 sets the mode to UNLOCK_RANGE, reading back 4. Data 2 sets LOCK_ALL, reading back 2. The mode is readable in bits [2:0] at select 0.
- R3: A write of 1 to the mode selects TIGHT, which reads back 1 and also shows as status bit 3. While in TIGHT, writes to the mode (select 0), range start (select 1) and range end (select 2) have no effect. Only reset leaves TIGHT.
- R4: A mode write whose full 16-bit data is anything other than 1, 2 or 4 leaves the mode unchanged.
- R5: The range start (select 1) and range end (select 2) are 16-bit block numbers. Outside TIGHT they are writable, and they read back at the same selects.
- R6: A request is forwarded one cycle after it is presented, with the same block number, only if the mode is UNLOCK_RANGE and start <= block <= end (both bounds included).
- R7: A refused request is not forwarded. It sets the violation flag, status bit 5 at select 4, which stays set until reset.
- R8: The buffer write grant follows the request in the same cycle only while the buffer key register (select 3) holds exactly 2. Any other value denies it, and TIGHT does not affect the key. Status bit 4 shows that the buffer is open.
- R9: With start 0x0000 and end 0xFFFF in UNLOCK_RANGE, blocks 0x0000 and 0xFFFF are both forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Write select: 0 mode, 1 start, 2 end, 3 buffer key |
| reg_wr_data | input | 16 | Write data |
| reg_rd_sel | input | 3 | Read select: 0 to 3 as for writes, 4 status |
| reg_rd_data | output | 16 | Read data (combinational) |
| req_valid | input | 1 | Program or erase request from the sequencer |
| req_block | input | 16 | Target block of the request |
| fwd_valid | output | 1 | Permitted request, passed on one cycle later |
| fwd_block | output | 16 | Block of the forwarded request |
| buf_wr_req | input | 1 | Host wants to write the buffer RAM |
| buf_wr_grant | output | 1 | Host buffer write permitted |

## Verification
Requests are presented at the two range bounds, inside the range, one block beyond each bound and at the extremes of a whole-device range. These patterns separate an inclusive bound from an exclusive or off-by-one compare. The same block is sent under LOCK_ALL, UNLOCK_RANGE and TIGHT, which shows that the mode gate is separate from the range gate. Mode writes with illegal codes, and range writes made while in TIGHT, are read back to show that they were ignored. Buffer key values of 2, 3 and 0x0102 separate a full-word key compare from a compare on the low bits only.

// File: rtl/nand_wp_pkg.sv
package nand_wp_pkg;

    typedef enum logic [2:0] {
        WP_TIGHT    = 3'd1,
        WP_LOCK_ALL = 3'd2,
        WP_UNLOCK   = 3'd4
    } wp_mode_e;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_START  = 3'd1,
        SEL_END    = 3'd2,
        SEL_BUFKEY = 3'd3,
        SEL_STATUS = 3'd4
    } reg_sel_e;

    localparam int STAT_TIGHT_BIT = 3;
    localparam int STAT_BUF_BIT   = 4;
    localparam int STAT_VIOL_BIT  = 5;

endpackage

// File: rtl/nand_wp_mode_fsm.sv
module nand_wp_mode_fsm
    import nand_wp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wr_data,
    output wp_mode_e          mode_q,
    output logic              tight,
    output logic              unlock
);
    wp_mode_e mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= WP_LOCK_ALL;
        else        mode_q <= mode_d;
    end

    // transitions: TIGHT is absorbing, illegal codes are ignored
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            WP_TIGHT: mode_d = WP_TIGHT;
            WP_LOCK_ALL, WP_UNLOCK: begin
                if (mode_wr) begin
                    if (wr_data == DATA_W'(WP_UNLOCK))        mode_d = WP_UNLOCK;
                    else if (wr_data == DATA_W'(WP_LOCK_ALL)) mode_d = WP_LOCK_ALL;
                    else if (wr_data == DATA_W'(WP_TIGHT))    mode_d = WP_TIGHT;
                end
            end
            default: mode_d = WP_LOCK_ALL;
        endcase
    end

    // output decode
    always_comb begin
        tight  = 1'b0;
        unlock = 1'b0;
        unique case (mode_q)
            WP_TIGHT:    tight  = 1'b1;
            WP_UNLOCK:   unlock = 1'b1;
            WP_LOCK_ALL: ;
            default:     ;
        endcase
    end
endmodule

// File: rtl/nand_wp_range_regs.sv
module nand_wp_range_regs #(
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_end,
    input  logic [BLK_W-1:0] wr_data,
    input  logic             frozen,
    output logic [BLK_W-1:0] start_q,
    output logic [BLK_W-1:0] end_q
);
    localparam int NUM_BOUNDS = 2;

    logic [BLK_W-1:0] bound_q [NUM_BOUNDS];
    logic             bound_we [NUM_BOUNDS];

    assign bound_we[0] = wr_start;
    assign bound_we[1] = wr_end;

    for (genvar g = 0; g < NUM_BOUNDS; g++) begin : g_bound
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       bound_q[g] <= '0;
            else if (bound_we[g] && !frozen)  bound_q[g] <= wr_data;
        end
    end

    assign start_q = bound_q[0];
    assign end_q   = bound_q[1];
endmodule

// File: rtl/nand_wp_req_gate.sv
module nand_wp_req_gate #(
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_block,
    input  logic             unlock,
    input  logic [BLK_W-1:0] lo_blk,
    input  logic [BLK_W-1:0] hi_blk,
    output logic             fwd_valid,
    output logic [BLK_W-1:0] fwd_block,
    output logic             violation
);
    logic in_range;
    logic permit;

    always_comb begin
        in_range = (req_block >= lo_blk) && (req_block <= hi_blk);
        permit   = unlock && in_range;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_block <= '0;
            violation <= 1'b0;
        end else begin
            fwd_valid <= req_valid && permit;
            if (req_valid && permit) fwd_block <= req_block;
            if (req_valid && !permit) violation <= 1'b1;
        end
    end
endmodule

// File: rtl/nand_wp_lock.sv
module nand_wp_lock
    import nand_wp_pkg::*;
#(
    parameter int BLK_W   = 16,
    parameter int DATA_W  = 16,
    parameter int BUF_KEY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [2:0]        reg_rd_sel,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_block,
    output logic              fwd_valid,
    output logic [BLK_W-1:0]  fwd_block,
    input  logic              buf_wr_req,
    output logic              buf_wr_grant
);
    wp_mode_e         mode_q;
    logic             tight;
    logic             unlock;
    logic [BLK_W-1:0] start_q;
    logic [BLK_W-1:0] end_q;
    logic [DATA_W-1:0] bufkey_q;
    logic             violation;
    logic             buf_open;
    logic             wr_mode, wr_start, wr_end, wr_key;

    always_comb begin
        wr_mode  = reg_wr_en && (reg_wr_sel == SEL_MODE);
        wr_start = reg_wr_en && (reg_wr_sel == SEL_START);
        wr_end   = reg_wr_en && (reg_wr_sel == SEL_END);
        wr_key   = reg_wr_en && (reg_wr_sel == SEL_BUFKEY);
    end

    nand_wp_mode_fsm #(.DATA_W(DATA_W)) mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (wr_mode),
        .wr_data (reg_wr_data),
        .mode_q  (mode_q),
        .tight   (tight),
        .unlock  (unlock)
    );

    nand_wp_range_regs #(.BLK_W(BLK_W)) range_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .wr_data  (reg_wr_data[BLK_W-1:0]),
        .frozen   (tight),
        .start_q  (start_q),
        .end_q    (end_q)
    );

    nand_wp_req_gate #(.BLK_W(BLK_W)) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_block (req_block),
        .unlock    (unlock),
        .lo_blk    (start_q),
        .hi_blk    (end_q),
        .fwd_valid (fwd_valid),
        .fwd_block (fwd_block),
        .violation (violation)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bufkey_q <= '0;
        else if (wr_key) bufkey_q <= reg_wr_data;
    end

    assign buf_open     = (bufkey_q == DATA_W'(BUF_KEY));
    assign buf_wr_grant = buf_wr_req && buf_open;

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_rd_sel)
            SEL_MODE:   reg_rd_data = DATA_W'(mode_q);
            SEL_START:  reg_rd_data = DATA_W'(start_q);
            SEL_END:    reg_rd_data = DATA_W'(end_q);
            SEL_BUFKEY: reg_rd_data = bufkey_q;
            SEL_STATUS: begin
                reg_rd_data[2:0]            = mode_q;
                reg_rd_data[STAT_TIGHT_BIT] = tight;
                reg_rd_data[STAT_BUF_BIT]   = buf_open;
                reg_rd_data[STAT_VIOL_BIT]  = violation;
            end
            default:    reg_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/nand_wp_lock_chk.sv
module nand_wp_lock_chk #(
    parameter int BLK_W   = 16,
    parameter int DATA_W  = 16,
    parameter int BUF_KEY = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode,
    input logic [BLK_W-1:0]  start_q,
    input logic [BLK_W-1:0]  end_q,
    input logic [DATA_W-1:0] bufkey_q,
    input logic              violation,
    input logic              req_valid,
    input logic              fwd_valid,
    input logic [BLK_W-1:0]  fwd_block,
    input logic              buf_wr_grant
);
    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode) == 1);

    assert_tight_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |=> (mode == 3'd1));

    assert_tight_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |=> ($stable(start_q) && $stable(end_q)));

    assert_fwd_needs_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ($past(mode) == 3'd4));

    assert_fwd_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ((fwd_block >= $past(start_q)) && (fwd_block <= $past(end_q))));

    assert_locked_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode != 3'd4)) |=> (violation && !fwd_valid));

    assert_violation_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

    assert_buf_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_grant |-> (bufkey_q == DATA_W'(BUF_KEY)));
endmodule

bind nand_wp_lock nand_wp_lock_chk #(.BLK_W(BLK_W), .DATA_W(DATA_W), .BUF_KEY(BUF_KEY)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode_q),
    .start_q      (start_q),
    .end_q        (end_q),
    .bufkey_q     (bufkey_q),
    .violation    (violation),
    .req_valid    (req_valid),
    .fwd_valid    (fwd_valid),
    .fwd_block    (fwd_block),
    .buf_wr_grant (buf_wr_grant)
);

// File: tb/nand_wp_lock_tb.sv
module nand_wp_lock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_sel = '0;
    logic [15:0] reg_rd_data;
    logic        req_valid = 1'b0;
    logic [15:0] req_block = '0;
    logic        fwd_valid;
    logic [15:0] fwd_block;
    logic        buf_wr_req = 1'b0;
    logic        buf_wr_grant;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nand_wp_lock dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .req_valid(req_valid), .req_block(req_block),
        .fwd_valid(fwd_valid), .fwd_block(fwd_block),
        .buf_wr_req(buf_wr_req), .buf_wr_grant(buf_wr_grant)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] val);
        reg_rd_sel = sel;
        #1;
        val = reg_rd_data;
    endtask

    // present one request; sample the outcome one edge later
    task automatic send(input logic [15:0] blk, output logic fv, output logic [15:0] fb);
        @(negedge clk);
        req_valid = 1'b1; req_block = blk;
        @(negedge clk);
        fv = fwd_valid; fb = fwd_block;
        req_valid = 1'b0;
    endtask

    task automatic t_reset_r1();
        logic [15:0] v;
        apply_reset();
        rd(3'd0, v); check("R1", "mode", v, 16'd2);
        rd(3'd1, v); check("R1", "start", v, 16'd0);
        rd(3'd2, v); check("R1", "end", v, 16'd0);
        rd(3'd3, v); check("R1", "bufkey", v, 16'd0);
        rd(3'd4, v); check("R1", "status", v, 16'h0002);
        buf_wr_req = 1'b1; #1;
        check("R1", "buffer grant", buf_wr_grant, 1'b0);
        buf_wr_req = 1'b0;
    endtask

    task automatic t_illegal_mode_r4();
        logic [15:0] v;
        wr(3'd0, 16'd3); rd(3'd0, v); check("R4", "mode after 3", v, 16'd2);
        wr(3'd0, 16'd0); rd(3'd0, v); check("R4", "mode after 0", v, 16'd2);
        wr(3'd0, 16'h0104); rd(3'd0, v); check("R4", "mode after 0x104", v, 16'd2);
    endtask

    task automatic t_range_r5_r2_r6();
        logic [15:0] v; logic fv; logic [15:0] fb;
        wr(3'd1, 16'd10); rd(3'd1, v); check("R5", "start", v, 16'd10);
        wr(3'd2, 16'd20); rd(3'd2, v); check("R5", "end", v, 16'd20);
        wr(3'd0, 16'd4);  rd(3'd0, v); check("R2", "unlock mode", v, 16'd4);
        send(16'd10, fv, fb); check("R6", "fwd at start", fv, 1'b1); check("R6", "block at start", fb, 16'd10);
        send(16'd20, fv, fb); check("R6", "fwd at end", fv, 1'b1); check("R6", "block at end", fb, 16'd20);
        send(16'd15, fv, fb); check("R6", "fwd inside", fv, 1'b1); check("R6", "block inside", fb, 16'd15);
        rd(3'd4, v); check("R6", "no violation yet", v[5], 1'b0);
    endtask

    task automatic t_refuse_r7_r2();
        logic [15:0] v; logic fv; logic [15:0] fb;
        send(16'd21, fv, fb); check("R7", "fwd above end", fv, 1'b0);
        rd(3'd4, v); check("R7", "violation set", v[5], 1'b1);
        send(16'd9, fv, fb); check("R7", "fwd below start", fv, 1'b0);
        wr(3'd0, 16'd2); rd(3'd0, v); check("R2", "lock-all mode", v, 16'd2);
        send(16'd15, fv, fb); check("R7", "fwd in lock-all", fv, 1'b0);
        repeat (3) @(negedge clk);
        rd(3'd4, v); check("R7", "violation sticky", v[5], 1'b1);
    endtask

    task automatic t_full_range_r9();
        logic fv; logic [15:0] fb;
        wr(3'd1, 16'h0000); wr(3'd2, 16'hFFFF); wr(3'd0, 16'd4);
        send(16'h0000, fv, fb); check("R9", "fwd block 0", fv, 1'b1); check("R9", "block 0", fb, 16'h0000);
        send(16'hFFFF, fv, fb); check("R9", "fwd block max", fv, 1'b1); check("R9", "block max", fb, 16'hFFFF);
    endtask

    task automatic t_tight_r3();
        logic [15:0] v; logic fv; logic [15:0] fb;
        wr(3'd0, 16'd1); rd(3'd0, v); check("R3", "tight mode", v, 16'd1);
        rd(3'd4, v); check("R3", "tight status bit", v[3], 1'b1);
        wr(3'd0, 16'd4); rd(3'd0, v); check("R3", "mode frozen", v, 16'd1);
        wr(3'd0, 16'd2); rd(3'd0, v); check("R3", "mode frozen 2", v, 16'd1);
        wr(3'd1, 16'd5); rd(3'd1, v); check("R3", "start frozen", v, 16'h0000);
        wr(3'd2, 16'd6); rd(3'd2, v); check("R3", "end frozen", v, 16'hFFFF);
        send(16'd7, fv, fb); check("R3", "fwd in tight", fv, 1'b0);
        apply_reset();
        rd(3'd0, v); check("R3", "reset leaves tight", v, 16'd2);
        rd(3'd4, v); check("R3", "reset clears violation", v[5], 1'b0);
    endtask

    task automatic t_buffer_r8();
        logic [15:0] v;
        buf_wr_req = 1'b1;
        wr(3'd3, 16'd2); #1; check("R8", "grant key 2", buf_wr_grant, 1'b1);
        rd(3'd4, v); check("R8", "buf status bit", v[4], 1'b1);
        wr(3'd3, 16'd3); #1; check("R8", "grant key 3", buf_wr_grant, 1'b0);
        wr(3'd3, 16'h0102); #1; check("R8", "grant key 0x102", buf_wr_grant, 1'b0);
        wr(3'd0, 16'd1); wr(3'd3, 16'd2); #1;
        check("R8", "grant in tight", buf_wr_grant, 1'b1);
        buf_wr_req = 1'b0; #1;
        check("R8", "no req no grant", buf_wr_grant, 1'b0);
        buf_wr_req = 1'b0;
    endtask

    initial begin
        t_reset_r1();
        t_illegal_mode_r4();
        t_range_r5_r2_r6();
        t_refuse_r7_r2();
        t_full_range_r9();
        t_tight_r3();
        t_buffer_r8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule